// File: doc/BRIEF.md
# Packed-Field Real-Time Clock Counter

This block keeps wall-clock time as a single 32-bit word. Seconds sit in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and a free-running day count in bits 31:17. A slow reference tick, such as a 32768 Hz pulse that has been made synchronous to the system clock, feeds a prescaler. The prescaler produces a half-second tick, and every second half-second tick advances the seconds field. Carries ripple from seconds into minutes, from minutes into hours and from hours into the day count.

The block compares the time of day against an alarm word. A match latches an alarm-pending flag, and that flag drives an alarm interrupt and a wakeup request, each through its own enable. Day, hour, minute, second and half-second events set their own pending flags, and these flags feed a shared periodic interrupt. A write port loads the counter, alarm, control and status words. Status bits are cleared by writing ones. A combinational read port returns any register, including a fixed identification word.

Top module: `packed_rtc`

## Requirements
- R1: The counter packs seconds [5:0], minutes [11:6], hours [16:12] and days [31:17]. While control bit 0 is set, every PRESCALE reference ticks make one half-second tick, and every second half-second tick adds one second.
- R2: Seconds and minutes go from 59 to 0, and hours go from 23 to 0, each with a carry into the next field. A field loaded at or above its limit also goes to 0 with a carry on its next step.
- R3: While control bit 0 is clear, the counter holds its value and the prescaler stays cleared. Status bit 0 reads back control bit 0, which shows whether the time is valid.
- R4: The day count is 15 bits wide and wraps from 32767 to 0 when the hour carry arrives.
- R5: An alarm write keeps only bits 16:0. The alarm word reads back with bits 31:17 at zero.
- R6: Status bit 2 (alarm pending) is set on a second tick when the new time of day in bits 16:0 equals the alarm word. The day field is not compared. Loading a counter value that already equals the alarm does not set the bit.
- R7: Writing the status word clears each of bits 7:2 that is written as 1. Bits written as 0 are unchanged. A new event in the same cycle wins over the clear.
- R8: The periodic pending flags are status bits 3 (day), 4 (hour), 5 (minute), 6 (second) and 7 (half-second). Each flag is set by its event whatever its enable is.
- R9: alarmIrq = status[2] & control[2]. wakeReq = status[2] & control[1]. tickIrq is the OR over k = 3..7 of status[k] & control[k].
- R10: Word addresses are 0 ID, 1 counter, 2 alarm, 3 control, 4 status. ID reads 0x030110 in bits 31:8 and 0x00 in bits 7:0. Unused addresses read 0.
- R11: A counter write takes priority over a same-cycle tick and restarts the prescaler. The next second tick comes a full 2*PRESCALE reference ticks after the write.
- R12: After reset the counter, alarm, control and status words are all zero and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle pulse per reference clock period |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Word address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Word address of the read |
| rdData | output | 32 | Read data, combinational |
| alarmIrq | output | 1 | Alarm interrupt |
| wakeReq | output | 1 | Alarm wakeup request |
| tickIrq | output | 1 | Periodic event interrupt |

## Verification
The assertions check on every cycle four properties. The counter does not move while it is stopped. A second tick either steps the seconds field by one or wraps it to zero. The alarm and day flags rise only on a second tick or at midnight. A write-one clear of the alarm flag takes effect unless a new match arrives in the same cycle. The bench scenarios are the only evidence for the rest: the exact cycle of each tick after an enable or a counter load, the carry chain across midnight and across the day wrap, the treatment of out-of-range fields, and the rule that an alarm equal to a freshly loaded time stays silent. A sweep over all sixty starting seconds, with an alarm set two seconds ahead, exercises the match at every seconds value.

// File: rtl/packed_rtc_pkg.sv
`timescale 1ns/1ps
package packed_rtc_pkg;
  // field geometry of the packed time word
  localparam int SEC_LSB  = 0;
  localparam int SEC_W    = 6;
  localparam int MIN_LSB  = SEC_LSB + SEC_W;
  localparam int MIN_W    = 6;
  localparam int HOUR_LSB = MIN_LSB + MIN_W;
  localparam int HOUR_W   = 5;
  localparam int DAY_LSB  = HOUR_LSB + HOUR_W;
  localparam int DAY_W    = 15;
  localparam int TOD_W    = DAY_LSB;
  localparam int WORD_W   = DAY_LSB + DAY_W;

  // identification word
  localparam logic [23:0] ID_CODE  = 24'h030110;
  localparam logic [7:0]  REV_CODE = 8'h00;

  // word addresses
  localparam logic [2:0] ADDR_ID    = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_ALARM = 3'd2;
  localparam logic [2:0] ADDR_CTRL  = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd4;

  // control bit positions (status pending bits share 2..7)
  localparam int CB_RUN  = 0;
  localparam int CB_WAKE = 1;
  localparam int CB_ALM  = 2;
  localparam int CB_DAY  = 3;
  localparam int CB_HALF = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic loadAlarm;
    logic halfTick;
    logic secTick;
  } dpStrobe_t;

  // events from datapath to control, ordered like status bits 7..2
  typedef struct packed {
    logic halfEv;
    logic secEv;
    logic minEv;
    logic hourEv;
    logic dayEv;
    logic alarmHit;
  } dpEvent_t;
endpackage

// File: rtl/rtc_field_step.sv
`timescale 1ns/1ps
module rtc_field_step #(
  parameter int W    = 6,
  parameter int MAXV = 59
) (
  input  logic [W-1:0] curVal,
  input  logic         carryIn,
  output logic [W-1:0] nextVal,
  output logic         carryOut
);
  localparam logic [W-1:0] LIMIT = W'(MAXV);

  always_comb begin
    nextVal  = curVal;
    carryOut = 1'b0;
    if (carryIn) begin
      if (curVal >= LIMIT) begin
        nextVal  = '0;
        carryOut = 1'b1;
      end else begin
        nextVal = curVal + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import packed_rtc_pkg::*;
#(
  parameter int SEC_MAX  = 59,
  parameter int MIN_MAX  = 59,
  parameter int HOUR_MAX = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] countQ,
  output logic [TOD_W-1:0]  alarmQ,
  output dpEvent_t          evt
);
  logic [SEC_W-1:0]  secNext;
  logic [MIN_W-1:0]  minNext;
  logic [HOUR_W-1:0] hourNext;
  logic [DAY_W-1:0]  dayNext;
  logic              secCarry, minCarry, hourCarry;
  logic [WORD_W-1:0] countNext;

  rtc_field_step #(.W(SEC_W), .MAXV(SEC_MAX)) uSec (
    .curVal  (countQ[SEC_LSB +: SEC_W]),
    .carryIn (stb.secTick),
    .nextVal (secNext),
    .carryOut(secCarry)
  );

  rtc_field_step #(.W(MIN_W), .MAXV(MIN_MAX)) uMin (
    .curVal  (countQ[MIN_LSB +: MIN_W]),
    .carryIn (secCarry),
    .nextVal (minNext),
    .carryOut(minCarry)
  );

  rtc_field_step #(.W(HOUR_W), .MAXV(HOUR_MAX)) uHour (
    .curVal  (countQ[HOUR_LSB +: HOUR_W]),
    .carryIn (minCarry),
    .nextVal (hourNext),
    .carryOut(hourCarry)
  );

  // day count wraps naturally at its width
  assign dayNext   = countQ[DAY_LSB +: DAY_W] + DAY_W'(hourCarry);
  assign countNext = {dayNext, hourNext, minNext, secNext};

  always_comb begin
    evt.halfEv   = stb.halfTick;
    evt.secEv    = stb.secTick;
    evt.minEv    = secCarry;
    evt.hourEv   = minCarry;
    evt.dayEv    = hourCarry;
    evt.alarmHit = stb.secTick && (countNext[TOD_W-1:0] == alarmQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      alarmQ <= '0;
    end else begin
      if (stb.loadCount) begin
        countQ <= wrData;
      end else if (stb.secTick) begin
        countQ <= countNext;
      end
      if (stb.loadAlarm) begin
        alarmQ <= wrData[TOD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rtc_control.sv
`timescale 1ns/1ps
module rtc_control
  import packed_rtc_pkg::*;
#(
  parameter int PRESCALE = 16384
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  dpEvent_t   evt,
  output dpStrobe_t  stb,
  output logic [7:0] ctrlQ,
  output logic [7:2] pendQ
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic             halfPhase;
  logic             runOn, wrCount, wrAlarm, wrCtrl, wrStat, preHit;
  logic [7:2]       pendSet, pendClr;

  assign runOn   = ctrlQ[CB_RUN];
  assign wrCount = wrEn && (wrAddr == ADDR_COUNT);
  assign wrAlarm = wrEn && (wrAddr == ADDR_ALARM);
  assign wrCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign wrStat  = wrEn && (wrAddr == ADDR_STAT);
  assign preHit  = runOn && refTick && (preCnt == PRE_LAST) && !wrCount;

  always_comb begin
    stb.loadCount = wrCount;
    stb.loadAlarm = wrAlarm;
    stb.halfTick  = preHit;
    stb.secTick   = preHit && halfPhase;
  end

  // prescaler and half-second phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      halfPhase <= 1'b0;
    end else if (!runOn || wrCount) begin
      preCnt    <= '0;
      halfPhase <= 1'b0;
    end else if (refTick) begin
      if (preCnt == PRE_LAST) begin
        preCnt    <= '0;
        halfPhase <= ~halfPhase;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign pendSet = evt;
  assign pendClr = wrStat ? wrData[7:2] : 6'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      pendQ <= '0;
    end else begin
      if (wrCtrl) begin
        ctrlQ <= wrData;
      end
      pendQ <= (pendQ & ~pendClr) | pendSet;
    end
  end
endmodule

// File: rtl/packed_rtc.sv
`timescale 1ns/1ps
module packed_rtc
  import packed_rtc_pkg::*;
#(
  parameter int PRESCALE = 16384
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [2:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        alarmIrq,
  output logic        wakeReq,
  output logic        tickIrq
);
  dpStrobe_t         stb;
  dpEvent_t          evt;
  logic [WORD_W-1:0] countQ;
  logic [TOD_W-1:0]  alarmQ;
  logic [7:0]        ctrlQ;
  logic [7:2]        pendQ;

  rtc_control #(.PRESCALE(PRESCALE)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .refTick(refTick),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData[7:0]),
    .evt    (evt),
    .stb    (stb),
    .ctrlQ  (ctrlQ),
    .pendQ  (pendQ)
  );

  rtc_datapath uDp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(wrData),
    .countQ(countQ),
    .alarmQ(alarmQ),
    .evt   (evt)
  );

  assign alarmIrq = pendQ[CB_ALM] && ctrlQ[CB_ALM];
  assign wakeReq  = pendQ[CB_ALM] && ctrlQ[CB_WAKE];
  assign tickIrq  = |(pendQ[CB_HALF:CB_DAY] & ctrlQ[CB_HALF:CB_DAY]);

  always_comb begin
    case (rdAddr)
      ADDR_ID:    rdData = {ID_CODE, REV_CODE};
      ADDR_COUNT: rdData = countQ;
      ADDR_ALARM: rdData = {{(WORD_W-TOD_W){1'b0}}, alarmQ};
      ADDR_CTRL:  rdData = {24'b0, ctrlQ};
      ADDR_STAT:  rdData = {24'b0, pendQ, 1'b0, ctrlQ[CB_RUN]};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/packed_rtc_chk.sv
`timescale 1ns/1ps
module packed_rtc_chk
  import packed_rtc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  wrAddr,
  input logic        wrBit2,
  input logic [31:0] countQ,
  input logic        runOn,
  input logic        almPend,
  input logic        dayPend,
  input logic        secTick
);
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !(wrEn && wrAddr == ADDR_COUNT)) |=> $stable(countQ)); // R3

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !(wrEn && wrAddr == ADDR_COUNT)) |=>
      (countQ[5:0] == 6'd0 || countQ[5:0] == 6'($past(countQ[5:0]) + 6'd1))); // R1

  AST_DAY_AT_MIDNIGHT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dayPend) |-> (countQ[16:0] == 17'd0)); // R2

  AST_ALARM_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almPend) |-> $past(secTick)); // R6

  AST_ALARM_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_STAT && wrBit2 && !secTick) |=> !almPend); // R7
endmodule

bind packed_rtc packed_rtc_chk uChk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrBit2 (wrData[2]),
  .countQ (countQ),
  .runOn  (ctrlQ[0]),
  .almPend(pendQ[2]),
  .dayPend(pendQ[3]),
  .secTick(stb.secTick)
);

// File: tb/sim_packed_rtc.sv
`timescale 1ns/1ps
module sim_packed_rtc;
  localparam int P = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [2:0]  rdAddr = 3'd0;
  logic [31:0] rdData;
  logic        alarmIrq, wakeReq, tickIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [31:0] mCount = '0;
  logic [16:0] mAlarm = '0;
  logic [7:0]  mCtrl = '0;
  logic [7:2]  mPend = '0;
  logic [7:2]  setv;
  int          n = 0;

  always #2 clk = ~clk;

  packed_rtc #(.PRESCALE(P)) u0 (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .alarmIrq(alarmIrq), .wakeReq(wakeReq), .tickIrq(tickIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.2;
    v = rdData;
  endtask

  function automatic logic [31:0] pack(input int d, input int h, input int m, input int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  // one second of time, field by field per R2/R4
  task automatic advance();
    logic [5:0] s, m; logic [4:0] h; logic [14:0] d;
    {d, h, m, s} = mCount;
    setv[6] = 1'b1;
    if (s >= 59) begin
      s = 0; setv[5] = 1'b1;
      if (m >= 59) begin
        m = 0; setv[4] = 1'b1;
        if (h >= 23) begin h = 0; setv[3] = 1'b1; d = d + 15'd1; end
        else h = h + 5'd1;
      end else m = m + 6'd1;
    end else s = s + 6'd1;
    mCount = {d, h, m, s};
    if (mCount[16:0] == mAlarm) setv[2] = 1'b1;
  endtask

  // one clock edge, optional write, then compare outputs with the model
  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd);
    logic [31:0] v;
    logic [7:2] clr;
    wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    setv = '0;
    if (we && wa == 3'd1) begin
      mCount = wd; n = 0;
    end else if (mCtrl[0]) begin
      n++;
      if (n % P == 0) begin
        setv[7] = 1'b1;
        if (n % (2*P) == 0) advance();
      end
    end else n = 0;
    if (we && wa == 3'd3) mCtrl = wd[7:0];
    if (we && wa == 3'd2) mAlarm = wd[16:0];
    clr = (we && wa == 3'd4) ? wd[7:2] : 6'b0;
    mPend = (mPend & ~clr) | setv;
    @(negedge clk);
    wrEn = 1'b0;
    readReg(3'd1, v); check("R1 count", v, mCount);
    readReg(3'd4, v); check("R8 status", v, {24'b0, mPend, 1'b0, mCtrl[0]});
    check("R9 irq", {29'b0, alarmIrq, wakeReq, tickIrq},
          {29'b0, mPend[2] & mCtrl[2], mPend[2] & mCtrl[1],
           |(mPend[7:3] & mCtrl[7:3])});
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 3'd0, 32'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    // R12 reset state and R10 address map
    readReg(3'd0, v); check("R10 id", v, 32'h03011000);
    for (int a = 1; a < 8; a++) begin
      readReg(3'(a), v); check("R12 reset reg", v, 32'd0);
    end
    check("R12 reset irq", {29'b0, alarmIrq, wakeReq, tickIrq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    readReg(3'd0, v); check("R10 id after reset", v, 32'h03011000);

    // R5 alarm width
    step(1'b1, 3'd2, 32'hFFFF_FFFF);
    readReg(3'd2, v); check("R5 alarm mask", v, 32'h0001_FFFF);

    // R1 R2 across midnight with alarm at 00:00:03
    step(1'b1, 3'd1, pack(5, 23, 59, 50));
    step(1'b1, 3'd2, pack(0, 0, 0, 3));
    step(1'b1, 3'd3, 32'hFF);
    idle(80);
    readReg(3'd1, v); check("R2 midnight carry", v, pack(6, 0, 0, 10));
    readReg(3'd4, v); check("R6 alarm pending", {31'b0, v[2]}, 32'd1);

    // R7 write-one-to-clear: alarm only, then zeros
    step(1'b1, 3'd4, 32'h04);
    readReg(3'd4, v); check("R7 clear alarm", {31'b0, v[2]}, 32'd0);
    step(1'b1, 3'd4, 32'h00);
    step(1'b1, 3'd4, 32'hFC);
    idle(40);
    readReg(3'd4, v); check("R6 no refire", {31'b0, v[2]}, 32'd0);

    // R3 stopped counter
    step(1'b1, 3'd3, 32'h00);
    readReg(3'd1, held);
    idle(20);
    readReg(3'd1, v); check("R3 hold", v, held);
    readReg(3'd4, v); check("R3 valid bit", {31'b0, v[0]}, 32'd0);

    // R2 out-of-range fields
    step(1'b1, 3'd1, pack(7, 22, 63, 62));
    step(1'b1, 3'd3, 32'h01);
    idle(12);
    readReg(3'd1, v); check("R2 over limit", v, pack(7, 23, 0, 2));

    // R4 day wrap
    step(1'b1, 3'd3, 32'h00);
    step(1'b1, 3'd1, pack(32767, 23, 59, 58));
    step(1'b1, 3'd3, 32'hF9);
    idle(16);
    readReg(3'd1, v); check("R4 day wrap", v, pack(0, 0, 0, 2));

    // R6 alarm equal to freshly loaded time stays silent
    step(1'b1, 3'd4, 32'hFC);
    step(1'b1, 3'd2, pack(0, 10, 20, 30));
    step(1'b1, 3'd3, 32'h07);
    step(1'b1, 3'd1, pack(3, 10, 20, 30));
    readReg(3'd4, v); check("R6 load no hit", {31'b0, v[2]}, 32'd0);
    idle(12);
    readReg(3'd4, v); check("R6 still silent", {31'b0, v[2]}, 32'd0);

    // R11 counter load restarts prescaler
    idle(1);
    step(1'b1, 3'd1, pack(1, 2, 3, 4));
    idle(2 * P - 1);
    readReg(3'd1, v); check("R11 held after load", v, pack(1, 2, 3, 4));
    idle(1);
    readReg(3'd1, v); check("R11 first tick", v, pack(1, 2, 3, 5));

    // R9 gating: alarm pending but interrupts disabled
    step(1'b1, 3'd2, pack(0, 2, 3, 6));
    idle(4 * P);
    step(1'b1, 3'd3, 32'h01);
    check("R9 gated off", {29'b0, alarmIrq, wakeReq, tickIrq}, 32'd0);

    // sweep every start second, alarm two seconds ahead
    for (int s = 0; s < 60; s++) begin
      step(1'b1, 3'd4, 32'hFC);
      step(1'b1, 3'd1, pack(s, 4, 59, s));
      step(1'b1, 3'd2, pack(0, (s >= 58) ? 5 : 4, (s >= 58) ? 0 : 59, (s + 2) % 60));
      step(1'b1, 3'd3, 32'h07);
      idle(3 * 2 * P);
      readReg(3'd4, v); check("R6 sweep hit", {31'b0, v[2]}, 32'd1);
      step(1'b1, 3'd3, 32'h00);
    end

    finish();
  end
endmodule